// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block gathers eighteen interrupt request lines and offers the CPU one winning request at a time, together with the five-bit index of that source. The sources are organised in six groups of three consecutive indices. Each group carries a two-bit priority level, and all three of its members use that level. A request is latched as pending on its rising edge. It becomes a candidate when its own enable and the global enable are both set. The controller presents the candidate with the highest level, and it settles ties by taking the lowest index.

Nesting is tracked as a record of the levels whose handlers are running. Accepting a request with `ack_i` marks its level as running. `ret_i` ends the most recent handler. A new request interrupts the running handler only when its level is strictly above the highest running level.

A wake output supports low-power operation. In the light idle state, any pending source that is individually enabled raises it. In the deeper sleep state, only the sources selected by a wake mask can raise it.

Top module: `gpic_top`

## Requirements
- R1: Source s belongs to group s/3. Its level is `grp_lvl_i[2g+1:2g]` for that group g. Level 3 is the highest and level 0 the lowest, and `lvl_o` reports the level of the presented source.
- R2: A source's pending flag (`pend_o[s]`) is set by a 0-to-1 transition of `req_i[s]` and is visible one clock after the edge. Holding the request high does not set the flag again after it has been cleared.
- R3: The flag of the source shown on `vec_o` is cleared by the clock edge at which `irq_o` and `ack_i` are both high. If a fresh rising edge on that same source arrives in that same cycle, the flag stays set.
- R4: A pending source whose `src_en_i` bit is low, or any source while `glob_en_i` is low, is never presented on `irq_o`/`vec_o`, and its pending flag is kept.
- R5: Among the eligible sources, the one with the highest level is chosen, and equal levels go to the lowest index. `vec_o` carries the binary index (0 to 17) and is meaningful while `irq_o` is high.
- R6: While any handler is running, `irq_o` is raised only for a candidate whose level is strictly greater than the highest running level.
- R7: An accepted acknowledge sets bit L of `act_map_o`, where L is the presented level. `ret_i` clears the highest set bit. `ret_i` with no running handler, and `ack_i` while `irq_o` is low, change nothing.
- R8: While `idle_i` is high, `wake_o` is high whenever some pending source has its `src_en_i` bit set, whatever the state of `glob_en_i`. Outside the low-power states `wake_o` is low.
- R9: While `deep_i` is high, only pending, enabled sources whose `wake_mask_i` bit is set raise `wake_o`. The deep state takes precedence over idle.
- R10: After a synchronous reset, no flag is pending, no handler is running, and `irq_o` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 18 | Request lines, one per source |
| src_en_i | input | 18 | Per-source enables |
| glob_en_i | input | 1 | Global enable for presenting requests |
| grp_lvl_i | input | 12 | Two-bit level per group, group g at bits 2g+1:2g |
| wake_mask_i | input | 18 | Sources allowed to wake from the deep state |
| idle_i | input | 1 | Light idle state indication |
| deep_i | input | 1 | Deep sleep state indication |
| ack_i | input | 1 | CPU accepts the presented request |
| ret_i | input | 1 | CPU returns from the current handler |
| irq_o | output | 1 | A request is presented |
| vec_o | output | 5 | Index of the presented source |
| lvl_o | output | 2 | Level of the presented source |
| pend_o | output | 18 | Pending flags |
| act_map_o | output | 4 | Running levels, one bit per level |
| wake_o | output | 1 | Return-to-active request |

## Verification
The bench goes after three kinds of error. The first is a tie at one level: a design that searched from the top index would present source 7 instead of source 1. The second is a request at a level equal to the running one: a design that compared with greater-or-equal would let a level-1 request break into a level-1 handler. The third is unwinding a three-deep nest: the held request should reappear only after the last return, and a wrong pop would free it too early or leave a level stuck as running. The bench also checks two more cases, an acknowledge that meets a fresh edge on the same source and a request held high across its acknowledge: a design that let the clear win, or that treated the request as level-sensitive, would lose a request or trigger again.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
    // Default sizing shared by the controller and its checker
    localparam int GPIC_NUM_SRC  = 18;
    localparam int GPIC_GRP_SIZE = 3;
    localparam int GPIC_LVL_W    = 2;

    // Index of the highest set bit of a level map, zero if empty
    function automatic int top_level(input logic [(1<<GPIC_LVL_W)-1:0] map);
        int res;
        res = 0;
        for (int l = 0; l < (1 << GPIC_LVL_W); l++) begin
            if (map[l]) res = l;
        end
        return res;
    endfunction
endpackage

// File: rtl/gpic_pend_bank.sv
// Pending flag bank.
// Captures a rising edge of each request line into a pending flag and clears
// one flag on request by index. Assumes requests are synchronous to clk.
// A new edge in the clear cycle keeps the flag set.
module gpic_pend_bank #(
    parameter int NUM_SRC = 18,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               clr_en_i,
    input  logic [IDX_W-1:0]   clr_idx_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] edge_det;

    // Per-source decode of the clear index
    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
            assign clr_mask[s] = clr_en_i && (clr_idx_i == IDX_W'(s));
        end
    endgenerate

    // Rising-edge detect on the request lines
    assign edge_det = req_i & ~req_q;

    // Hold previous request state and update pending flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            pend_o <= '0;
        end else begin
            req_q  <= req_i;
            pend_o <= (pend_o & ~clr_mask) | edge_det;
        end
    end
endmodule

// File: rtl/gpic_arbiter.sv
// Level arbiter.
// Expands the per-group level to each source and picks, among eligible
// sources, the highest level and within it the lowest index. Purely
// combinational; assumes NUM_SRC is a multiple of GRP_SIZE.
module gpic_arbiter #(
    parameter int NUM_SRC  = 18,
    parameter int GRP_SIZE = 3,
    parameter int LVL_W    = 2,
    parameter int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]                  elig_i,
    input  logic [NUM_SRC/GRP_SIZE*LVL_W-1:0]   grp_lvl_i,
    output logic                                found_o,
    output logic [IDX_W-1:0]                    vec_o,
    output logic [LVL_W-1:0]                    lvl_o
);
    localparam int NUM_LVL = 1 << LVL_W;

    logic [LVL_W-1:0]   src_lvl [NUM_SRC];
    logic [NUM_SRC-1:0] hit;
    logic [NUM_SRC-1:0] best_mask;

    // Each source inherits its group's level
    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
            assign src_lvl[s] = grp_lvl_i[(s / GRP_SIZE) * LVL_W +: LVL_W];
        end
    endgenerate

    // Scan levels upward so the highest level with a hit wins
    always_comb begin
        found_o   = 1'b0;
        lvl_o     = '0;
        best_mask = '0;
        hit       = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                hit[s] = elig_i[s] && (src_lvl[s] == LVL_W'(l));
            end
            if (|hit) begin
                found_o   = 1'b1;
                lvl_o     = LVL_W'(l);
                best_mask = hit;
            end
        end
    end

    // Lowest index inside the winning level
    always_comb begin
        vec_o = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (best_mask[s]) vec_o = IDX_W'(s);
        end
    end
endmodule

// File: rtl/gpic_nest_stack.sv
// Nesting record.
// Keeps one bit per level for handlers in progress. Because preemption needs
// a strictly higher level, each level appears at most once, so the most
// recent entry is always the highest set bit. Pop applies before push.
module gpic_nest_stack #(
    parameter int LVL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  logic [LVL_W-1:0]      push_lvl_i,
    input  logic                  pop_i,
    output logic [(1<<LVL_W)-1:0] map_o,
    output logic                  busy_o,
    output logic [LVL_W-1:0]      top_lvl_o
);
    localparam int NUM_LVL = 1 << LVL_W;

    logic [NUM_LVL-1:0] map_nxt;

    // Highest running level
    always_comb begin
        top_lvl_o = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (map_o[l]) top_lvl_o = LVL_W'(l);
        end
    end

    assign busy_o = |map_o;

    // Next map: drop the top on return, then add the accepted level
    always_comb begin
        map_nxt = map_o;
        if (pop_i && busy_o) map_nxt[top_lvl_o] = 1'b0;
        if (push_i)          map_nxt[push_lvl_i] = 1'b1;
    end

    // Level map register
    always_ff @(posedge clk) begin
        if (!rst_n) map_o <= '0;
        else        map_o <= map_nxt;
    end
endmodule

// File: rtl/gpic_top.sv
// Grouped-priority interrupt controller, top level.
// Combines pending capture, level arbitration, nesting record and the wake
// path. irq_o/vec_o/lvl_o are combinational from registered state and the
// enable/level inputs; the CPU accepts with ack_i and leaves with ret_i.
module gpic_top #(
    parameter int NUM_SRC  = gpic_pkg::GPIC_NUM_SRC,
    parameter int GRP_SIZE = gpic_pkg::GPIC_GRP_SIZE,
    parameter int LVL_W    = gpic_pkg::GPIC_LVL_W,
    parameter int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_SRC-1:0]                  req_i,
    input  logic [NUM_SRC-1:0]                  src_en_i,
    input  logic                                glob_en_i,
    input  logic [NUM_SRC/GRP_SIZE*LVL_W-1:0]   grp_lvl_i,
    input  logic [NUM_SRC-1:0]                  wake_mask_i,
    input  logic                                idle_i,
    input  logic                                deep_i,
    input  logic                                ack_i,
    input  logic                                ret_i,
    output logic                                irq_o,
    output logic [IDX_W-1:0]                    vec_o,
    output logic [LVL_W-1:0]                    lvl_o,
    output logic [NUM_SRC-1:0]                  pend_o,
    output logic [(1<<LVL_W)-1:0]               act_map_o,
    output logic                                wake_o
);
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] wake_src;
    logic               cand_found;
    logic [IDX_W-1:0]   cand_vec;
    logic [LVL_W-1:0]   cand_lvl;
    logic               busy;
    logic [LVL_W-1:0]   top_lvl;
    logic               take;

    // Pending capture and clear on accepted acknowledge
    gpic_pend_bank #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .clr_en_i  (take),
        .clr_idx_i (cand_vec),
        .pend_o    (pend_o)
    );

    // Sources that may be presented
    assign elig = pend_o & src_en_i & {NUM_SRC{glob_en_i}};

    // Highest level, lowest index among eligible sources
    gpic_arbiter #(
        .NUM_SRC  (NUM_SRC),
        .GRP_SIZE (GRP_SIZE),
        .LVL_W    (LVL_W),
        .IDX_W    (IDX_W)
    ) u_arb (
        .elig_i    (elig),
        .grp_lvl_i (grp_lvl_i),
        .found_o   (cand_found),
        .vec_o     (cand_vec),
        .lvl_o     (cand_lvl)
    );

    // Present only when idle of handlers or strictly above the running level
    assign irq_o = cand_found && (!busy || (cand_lvl > top_lvl));
    assign vec_o = cand_vec;
    assign lvl_o = cand_lvl;
    assign take  = irq_o && ack_i;

    // Record of running handler levels
    gpic_nest_stack #(
        .LVL_W (LVL_W)
    ) u_nest (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .push_lvl_i (cand_lvl),
        .pop_i      (ret_i),
        .map_o      (act_map_o),
        .busy_o     (busy),
        .top_lvl_o  (top_lvl)
    );

    // Wake sources: all enabled in idle, masked subset in deep sleep
    assign wake_src = pend_o & src_en_i & (deep_i ? wake_mask_i : {NUM_SRC{1'b1}});
    assign wake_o   = (idle_i || deep_i) && (|wake_src);
endmodule

// File: rtl/gpic_checker.sv
// Property checker for gpic_top, attached by bind below.
// Observes ports only and keeps a few registers of its own for edge and
// acknowledge history.
module gpic_checker #(
    parameter int NUM_SRC  = gpic_pkg::GPIC_NUM_SRC,
    parameter int GRP_SIZE = gpic_pkg::GPIC_GRP_SIZE,
    parameter int LVL_W    = gpic_pkg::GPIC_LVL_W,
    parameter int IDX_W    = $clog2(NUM_SRC)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_SRC-1:0]                req_i,
    input logic [NUM_SRC-1:0]                src_en_i,
    input logic                              glob_en_i,
    input logic [NUM_SRC/GRP_SIZE*LVL_W-1:0] grp_lvl_i,
    input logic [NUM_SRC-1:0]                wake_mask_i,
    input logic                              idle_i,
    input logic                              deep_i,
    input logic                              ack_i,
    input logic                              ret_i,
    input logic                              irq_o,
    input logic [IDX_W-1:0]                  vec_o,
    input logic [LVL_W-1:0]                  lvl_o,
    input logic [NUM_SRC-1:0]                pend_o,
    input logic [(1<<LVL_W)-1:0]             act_map_o,
    input logic                              wake_o
);
    logic [NUM_SRC-1:0] req_d;
    logic               take_d;
    logic               keep_d;
    logic [IDX_W-1:0]   vec_d;

    // History of requests and of the last accepted acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d  <= '0;
            take_d <= 1'b0;
            keep_d <= 1'b0;
            vec_d  <= '0;
        end else begin
            req_d  <= req_i;
            take_d <= irq_o && ack_i;
            keep_d <= req_i[vec_o] && !req_d[vec_o];
            vec_d  <= vec_o;
        end
    end

    assert_lvl_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (lvl_o == grp_lvl_i[(int'(vec_o) / GRP_SIZE) * LVL_W +: LVL_W]));

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_edge
            assert_set_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend_o[s]) |-> $past(req_i[s] && !req_d[s]));
        end
    endgenerate

    assert_ack_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_d && !keep_d) |-> !pend_o[vec_d]);

    assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (glob_en_i && src_en_i[vec_o] && pend_o[vec_o]));

    assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (int'(vec_o) < NUM_SRC));

    assert_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && (act_map_o != '0)) |-> (int'(lvl_o) > gpic_pkg::top_level(act_map_o)));

    assert_stack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !ret_i) |=> $stable(act_map_o));

    assert_wake_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (idle_i || deep_i));

    assert_wake_deep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_i && wake_o) |-> (|(pend_o & src_en_i & wake_mask_i)));
endmodule

bind gpic_top gpic_checker #(
    .NUM_SRC  (NUM_SRC),
    .GRP_SIZE (GRP_SIZE),
    .LVL_W    (LVL_W),
    .IDX_W    (IDX_W)
) u_gpic_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .src_en_i    (src_en_i),
    .glob_en_i   (glob_en_i),
    .grp_lvl_i   (grp_lvl_i),
    .wake_mask_i (wake_mask_i),
    .idle_i      (idle_i),
    .deep_i      (deep_i),
    .ack_i       (ack_i),
    .ret_i       (ret_i),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .lvl_o       (lvl_o),
    .pend_o      (pend_o),
    .act_map_o   (act_map_o),
    .wake_o      (wake_o)
);

// File: tb/tb_gpic_top.sv
module tb_gpic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] req_i = '0;
    logic [17:0] src_en_i = '0;
    logic        glob_en_i = 1'b0;
    logic [11:0] grp_lvl_i = '0;
    logic [17:0] wake_mask_i = '0;
    logic        idle_i = 1'b0;
    logic        deep_i = 1'b0;
    logic        ack_i = 1'b0;
    logic        ret_i = 1'b0;
    logic        irq_o;
    logic [4:0]  vec_o;
    logic [1:0]  lvl_o;
    logic [17:0] pend_o;
    logic [3:0]  act_map_o;
    logic        wake_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    gpic_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .src_en_i(src_en_i),
        .glob_en_i(glob_en_i), .grp_lvl_i(grp_lvl_i), .wake_mask_i(wake_mask_i),
        .idle_i(idle_i), .deep_i(deep_i), .ack_i(ack_i), .ret_i(ret_i),
        .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o), .pend_o(pend_o),
        .act_map_o(act_map_o), .wake_o(wake_o)
    );

    // Table: request pulse, enables, group levels, expected irq and vector
    localparam int NT = 8;
    localparam logic [17:0] T_REQ [NT] = '{18'h00010, 18'h00082, 18'h00082, 18'h10004,
                                          18'h20000, 18'h20001, 18'h00038, 18'h03000};
    localparam logic [17:0] T_EN  [NT] = '{18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF,
                                          18'h1FFFF, 18'h3FFFE, 18'h3FFFF, 18'h3FFFF};
    localparam logic [11:0] T_LVL [NT] = '{12'h000, 12'h000, 12'h020, 12'hC01,
                                          12'h000, 12'h000, 12'h004, 12'h300};
    localparam logic        T_IRQ [NT] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [4:0]  T_VEC [NT] = '{5'd4, 5'd1, 5'd7, 5'd16, 5'd0, 5'd17, 5'd3, 5'd12};

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_i = '0; ack_i = 1'b0; ret_i = 1'b0;
        idle_i = 1'b0; deep_i = 1'b0; wake_mask_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One-cycle request pulse; flags are visible at the following negedge
    task automatic pulse(input logic [17:0] m);
        @(negedge clk); req_i = m;
        @(negedge clk); req_i = '0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack_i = 1'b1;
        @(negedge clk); ack_i = 1'b0;
    endtask

    task automatic do_ret();
        @(negedge clk); ret_i = 1'b1;
        @(negedge clk); ret_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R10 reset state
        do_reset();
        #1;
        check("R10 pend", int'(pend_o), 0);
        check("R10 act", int'(act_map_o), 0);
        check("R10 irq", int'(irq_o), 0);
        check("R10 wake", int'(wake_o), 0);

        // Table walk: R1/R5 selection, R4 enable masking
        for (int i = 0; i < NT; i++) begin
            do_reset();
            src_en_i = T_EN[i]; grp_lvl_i = T_LVL[i]; glob_en_i = 1'b1;
            pulse(T_REQ[i]);
            #1;
            check("R1/R5/R4 table irq", int'(irq_o), int'(T_IRQ[i]));
            if (T_IRQ[i]) check("R1/R5 table vec", int'(vec_o), int'(T_VEC[i]));
            check("R2/R4 table pend", int'(pend_o), int'(T_REQ[i]));
        end

        // R2: held request sets once; no retrigger after ack
        do_reset();
        src_en_i = '1; grp_lvl_i = '0; glob_en_i = 1'b0;
        @(negedge clk); req_i = 18'h00020;
        @(negedge clk); #1;
        check("R2 pend set", int'(pend_o[5]), 1);
        check("R4 global off irq", int'(irq_o), 0);
        glob_en_i = 1'b1; #1;
        check("R4 global on vec", int'(vec_o), 5);
        do_ack();
        @(negedge clk); @(negedge clk); #1;
        check("R2 no retrigger", int'(pend_o[5]), 0);
        req_i = '0;

        // R3: fresh edge in the ack cycle keeps the flag
        do_reset();
        src_en_i = '1; grp_lvl_i = '0; glob_en_i = 1'b1;
        pulse(18'h00020);
        @(negedge clk); ack_i = 1'b1; req_i = 18'h00020;
        @(negedge clk); ack_i = 1'b0; req_i = '0; #1;
        check("R3 edge wins", int'(pend_o[5]), 1);
        check("R7 pushed level 0", int'(act_map_o), 1);

        // R3/R6: ack clears, equal level waits until return
        do_reset();
        src_en_i = '1; grp_lvl_i = '0; glob_en_i = 1'b1;
        pulse(18'h00204);
        #1; check("R5 first vec", int'(vec_o), 2);
        do_ack(); #1;
        check("R3 cleared", int'(pend_o), 18'h00200);
        check("R6 equal blocked", int'(irq_o), 0);
        do_ret(); #1;
        check("R7 ret frees", int'(vec_o), 9);
        check("R6 after ret irq", int'(irq_o), 1);

        // R6/R7: three-deep nesting
        do_reset();
        src_en_i = '1; grp_lvl_i = 12'h039; glob_en_i = 1'b1;
        pulse(18'h00001); do_ack(); #1;
        check("R7 map lvl1", int'(act_map_o), 4'b0010);
        pulse(18'h00008); #1;
        check("R6 higher preempts", int'(vec_o), 3);
        do_ack(); #1;
        check("R7 map lvl2", int'(act_map_o), 4'b0110);
        pulse(18'h00002); #1;
        check("R6 lower blocked", int'(irq_o), 0);
        pulse(18'h00040); #1;
        check("R6 top level vec", int'(vec_o), 6);
        do_ack(); #1;
        check("R7 map lvl3", int'(act_map_o), 4'b1110);
        do_ret(); #1;
        check("R7 pop to lvl2", int'(act_map_o), 4'b0110);
        check("R6 still blocked", int'(irq_o), 0);
        do_ret(); #1;
        check("R6 equal lvl1 blocked", int'(irq_o), 0);
        do_ack(); #1;
        check("R7 ack without irq map", int'(act_map_o), 4'b0010);
        check("R7 ack without irq pend", int'(pend_o[1]), 1);
        do_ret(); do_ret(); #1;
        check("R7 empty ret ignored", int'(act_map_o), 0);
        check("R6 freed vec", int'(vec_o), 1);

        // R8/R9: wake path
        do_reset();
        src_en_i = '1; grp_lvl_i = '0; glob_en_i = 1'b0;
        pulse(18'h00400);
        idle_i = 1'b1; #1;
        check("R8 idle wake", int'(wake_o), 1);
        check("R4 no irq while global off", int'(irq_o), 0);
        idle_i = 1'b0; deep_i = 1'b1; #1;
        check("R9 deep masked", int'(wake_o), 0);
        idle_i = 1'b1; #1;
        check("R9 deep over idle", int'(wake_o), 0);
        wake_mask_i = 18'h00400; #1;
        check("R9 deep allowed", int'(wake_o), 1);
        src_en_i = 18'h3FBFF; #1;
        check("R9 disabled source", int'(wake_o), 0);
        src_en_i = '1; deep_i = 1'b0; idle_i = 1'b0; #1;
        check("R8 active no wake", int'(wake_o), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule